// File: doc/BRIEF.md
# Hot-Plug Poll Sequencer

This block decides when a hot-plug controller gets sampled. It runs a timed loop. A sleep interval, set by a clock-cycle prescaler, separates the polling passes. Most passes are cheap: they read only the latch register of the controller. Every fifth completed pass is followed by a full pass instead, which reads the status of each slot in turn. A full pass ends by re-reading the latch register, so that the latch baseline stays current.

On every latch read, the sequencer keeps the previous byte and the new byte. It pulses a change flag when the two differ. The register reads are carried out by an external read engine, which sees a request channel and answers with a response pulse.

A shutdown request is remembered whenever it arrives. The current pass still runs to its end, followed by its sleep. When that sleep expires, the sequencer reports a one-cycle halt pulse instead of starting another pass. It then stays silent until reset.

The request channel follows valid/ready rules, with the response pulse serving as ready:
- `req_valid_o`, together with its kind and slot fields, stays high and stable for as long as the engine takes to respond. This is how the engine applies back-pressure, and it may do so for any number of cycles.
- A response is accepted on the clock edge where `rsp_valid_i` and `req_valid_o` are both high.

Top module: `hp_poll_seq`

## Requirements
- R1: During reset and after its release, `req_valid_o`, `latch_chg_o`, `stat_valid_o` and `halt_done_o` are 0. The first request appears exactly SLEEP_CYCLES cycles after reset is released.
- R2: After the last accepted response of a pass, `req_valid_o` stays low for exactly SLEEP_CYCLES cycles before the next request, or before the halt pulse.
- R3: A pass counter starts at 0 and increments when each pass ends. When a sleep expires with the counter at SCAN_EVERY, the counter is cleared and a full pass follows. Otherwise a latch pass follows. With the default of 5, passes 1 to 5 after reset are latch passes, pass 6 is full, and after that every fifth pass is full.
- R4: A latch pass issues exactly one request, with `req_latch_o`=1 and `req_slot_o`=0.
- R5: In a latch pass, `latch_chg_o` pulses for one cycle, in the cycle after the response is accepted, if the new byte differs from the stored baseline. In the same cycle, `latch_cur_o` shows the new byte and `latch_prev_o` shows the former baseline.
- R6: The first latch byte captured after reset only sets the baseline. It never raises `latch_chg_o`.
- R7: A full pass requests slots 0 to NUM_SLOTS-1 in ascending order with `req_latch_o`=0. Each result appears on `stat_valid_o`, `stat_slot_o` and `stat_data_o` in the cycle after its response is accepted. The pass then issues one request with `req_latch_o`=1. That read updates the baseline and never raises `latch_chg_o`.
- R8: While `req_valid_o` is high and no response has been accepted, `req_valid_o`, `req_latch_o` and `req_slot_o` hold their values.
- R9: A `rsp_valid_i` pulse while `req_valid_o` is low has no effect: no pulse on `latch_chg_o` or `stat_valid_o`, and `latch_cur_o` is unchanged.
- R10: A one-cycle pulse on `shutdown_i` at any time is remembered. At the next expiry of a sleep, `halt_done_o` pulses for one cycle in place of a request. After that, no request and no further halt pulse occur until reset.
- R11: A shutdown that arrives during a pass does not cut the pass short. Every remaining request of that pass is still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shutdown_i | input | 1 | Stop request; a single-cycle pulse is enough |
| req_valid_o | output | 1 | A read request is pending |
| req_latch_o | output | 1 | 1 = read the latch register, 0 = read a slot status |
| req_slot_o | output | SLOT_W | Slot index for a status read (0 for latch reads) |
| rsp_valid_i | input | 1 | Response/accept pulse from the read engine |
| rsp_data_i | input | DATA_W | Byte returned with the response |
| latch_cur_o | output | DATA_W | Current latch baseline |
| latch_prev_o | output | DATA_W | Baseline that was in place before the last latch capture |
| latch_chg_o | output | 1 | One-cycle pulse: a latch pass saw a different byte |
| stat_valid_o | output | 1 | One-cycle pulse: a slot status byte is presented |
| stat_slot_o | output | SLOT_W | Slot that the status byte belongs to |
| stat_data_o | output | DATA_W | Slot status byte |
| halt_done_o | output | 1 | One-cycle pulse: the sequencer has stopped |

## Verification
A request is visible in the cycle that follows the clock edge on which a sleep expires. The bench therefore counts low-`req_valid_o` falling edges from the point where a pass ends, and expects exactly SLEEP_CYCLES of them. Every result that depends on a response (the change flag, the latch bytes and the slot status) is registered once. It is checked at the first falling edge after the edge that accepted the response. The request fields are checked at each falling edge of a randomly chosen wait before the response. The halt pulse is expected at the same falling edge where the next request would otherwise have appeared. After it, the bench watches a quiet window of cycles.

// File: rtl/hps_pkg.sv
`timescale 1ns/1ps
package hps_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_LATCH   = 3'd1,
    ST_SCAN    = 3'd2,
    ST_RELATCH = 3'd3,
    ST_HALT    = 3'd4,
    ST_STOP    = 3'd5
  } hps_state_t;
endpackage

// File: rtl/hps_prescaler.sv
`timescale 1ns/1ps
// Counts clock cycles while run is high; expire marks the last cycle of the interval.
module hps_prescaler #(
  parameter int unsigned CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hps_pass_ctr.sv
`timescale 1ns/1ps
// Counts completed passes; full_due says a full scan is owed.
module hps_pass_ctr #(
  parameter int unsigned SCAN_EVERY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  input  logic clr,
  output logic full_due
);
  localparam int PASS_W = $clog2(SCAN_EVERY + 1);
  localparam logic [PASS_W-1:0] TRIP = PASS_W'(SCAN_EVERY);

  logic [PASS_W-1:0] cnt_q;

  assign full_due = (cnt_q == TRIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (bump && !full_due) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hps_slot_walk.sv
`timescale 1ns/1ps
// Slot index for the full scan: steps 0..NUM_SLOTS-1 and wraps.
module hps_slot_walk #(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [SLOT_W-1:0] idx,
  output logic              last
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] idx_q;

  assign idx  = idx_q;
  assign last = (idx_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clr) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/hps_latch_track.sv
`timescale 1ns/1ps
// Holds the latch baseline, the byte before it, and raises the change pulse.
module hps_latch_track #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              report,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] prev,
  output logic              chg
);
  logic [DATA_W-1:0] cur_q, prev_q;
  logic              have_q, chg_q;

  assign cur  = cur_q;
  assign prev = prev_q;
  assign chg  = chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      have_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= cap && report && have_q && (data != cur_q);
      if (cap) begin
        prev_q <= cur_q;
        cur_q  <= data;
        have_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hp_poll_seq.sv
`timescale 1ns/1ps
module hp_poll_seq #(
  parameter int unsigned SLEEP_CYCLES = 250_000_000,
  parameter int unsigned NUM_SLOTS    = 6,
  parameter int unsigned SCAN_EVERY   = 5,
  parameter int          DATA_W       = 8,
  localparam int         SLOT_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown_i,
  output logic              req_valid_o,
  output logic              req_latch_o,
  output logic [SLOT_W-1:0] req_slot_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic [DATA_W-1:0] latch_cur_o,
  output logic [DATA_W-1:0] latch_prev_o,
  output logic              latch_chg_o,
  output logic              stat_valid_o,
  output logic [SLOT_W-1:0] stat_slot_o,
  output logic [DATA_W-1:0] stat_data_o,
  output logic              halt_done_o
);
  import hps_pkg::*;

  hps_state_t        state_q, state_d;
  logic              stop_pend_q;
  logic              expire, full_due;
  logic              acc;
  logic [SLOT_W-1:0] slot_idx;
  logic              slot_last;
  logic              stat_valid_q;
  logic [SLOT_W-1:0] stat_slot_q;
  logic [DATA_W-1:0] stat_data_q;

  // request channel
  assign req_valid_o = (state_q == ST_LATCH) || (state_q == ST_SCAN) ||
                       (state_q == ST_RELATCH);
  assign req_latch_o = (state_q == ST_LATCH) || (state_q == ST_RELATCH);
  assign req_slot_o  = (state_q == ST_SCAN) ? slot_idx : '0;
  assign acc         = req_valid_o && rsp_valid_i;
  assign halt_done_o = (state_q == ST_HALT);

  hps_prescaler #(.CYCLES(SLEEP_CYCLES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == ST_SLEEP),
    .expire (expire)
  );

  hps_pass_ctr #(.SCAN_EVERY(SCAN_EVERY)) u_pass (
    .clk      (clk),
    .rst_n    (rst_n),
    .bump     (acc && req_latch_o),
    .clr      (expire && !stop_pend_q && full_due),
    .full_due (full_due)
  );

  hps_slot_walk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_SLEEP),
    .step  (acc && (state_q == ST_SCAN)),
    .idx   (slot_idx),
    .last  (slot_last)
  );

  hps_latch_track #(.DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (acc && req_latch_o),
    .report (state_q == ST_LATCH),
    .data   (rsp_data_i),
    .cur    (latch_cur_o),
    .prev   (latch_prev_o),
    .chg    (latch_chg_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLEEP: begin
        if (expire) begin
          if (stop_pend_q)   state_d = ST_HALT;
          else if (full_due) state_d = ST_SCAN;
          else               state_d = ST_LATCH;
        end
      end
      ST_LATCH:   if (acc) state_d = ST_SLEEP;
      ST_SCAN:    if (acc && slot_last) state_d = ST_RELATCH;
      ST_RELATCH: if (acc) state_d = ST_SLEEP;
      ST_HALT:    state_d = ST_STOP;
      ST_STOP:    state_d = ST_STOP;
      default:    state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_SLEEP;
      stop_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (shutdown_i) stop_pend_q <= 1'b1;
    end
  end

  // slot status presentation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid_q <= 1'b0;
      stat_slot_q  <= '0;
      stat_data_q  <= '0;
    end else begin
      stat_valid_q <= acc && (state_q == ST_SCAN);
      if (acc && (state_q == ST_SCAN)) begin
        stat_slot_q <= slot_idx;
        stat_data_q <= rsp_data_i;
      end
    end
  end

  assign stat_valid_o = stat_valid_q;
  assign stat_slot_o  = stat_slot_q;
  assign stat_data_o  = stat_data_q;
endmodule

// File: rtl/hp_poll_seq_chk.sv
`timescale 1ns/1ps
module hp_poll_seq_chk #(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int          SLOT_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_o,
  input logic              req_latch_o,
  input logic [SLOT_W-1:0] req_slot_o,
  input logic              rsp_valid_i,
  input logic              latch_chg_o,
  input logic              stat_valid_o,
  input logic              halt_done_o
);
  logic halted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else if (halt_done_o) halted_q <= 1'b1;
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !rsp_valid_i) |=>
      (req_valid_o && $stable(req_latch_o) && $stable(req_slot_o)));

  a_r5_chg_after_latch_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    latch_chg_o |-> $past(req_valid_o && rsp_valid_i && req_latch_o));

  a_r5_chg_single: assert property (@(posedge clk) disable iff (!rst_n)
    latch_chg_o |=> !latch_chg_o);

  a_r7_stat_after_slot_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> $past(req_valid_o && rsp_valid_i && !req_latch_o));

  a_r7_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_latch_o) |-> (int'(req_slot_o) < NUM_SLOTS));

  a_r9_stray_rsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid_o && rsp_valid_i) |=> (!latch_chg_o && !stat_valid_o));

  a_r10_halt_single: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done_o |=> !halt_done_o);

  a_r10_quiet_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> (!req_valid_o && !halt_done_o));

  a_r10_no_req_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_done_o && req_valid_o));
endmodule

bind hp_poll_seq hp_poll_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_o  (req_valid_o),
  .req_latch_o  (req_latch_o),
  .req_slot_o   (req_slot_o),
  .rsp_valid_i  (rsp_valid_i),
  .latch_chg_o  (latch_chg_o),
  .stat_valid_o (stat_valid_o),
  .halt_done_o  (halt_done_o)
);

// File: tb/sim_hp_poll_seq.sv
`timescale 1ns/1ps
module sim_hp_poll_seq;
  localparam int SLEEP = 20;
  localparam int NS    = 4;
  localparam int EVERY = 5;
  localparam int DW    = 8;
  localparam int SW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shutdown_i = 1'b0;
  logic          req_valid_o, req_latch_o;
  logic [SW-1:0] req_slot_o;
  logic          rsp_valid_i = 1'b0;
  logic [DW-1:0] rsp_data_i = '0;
  logic [DW-1:0] latch_cur_o, latch_prev_o, stat_data_o;
  logic          latch_chg_o, stat_valid_o, halt_done_o;
  logic [SW-1:0] stat_slot_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  logic [DW-1:0] exp_base = '0;
  bit            have_base = 1'b0;
  int            exp_pass = 0;

  always #4ns clk = ~clk;

  hp_poll_seq #(.SLEEP_CYCLES(SLEEP), .NUM_SLOTS(NS), .SCAN_EVERY(EVERY), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown_i),
    .req_valid_o(req_valid_o), .req_latch_o(req_latch_o), .req_slot_o(req_slot_o),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .latch_cur_o(latch_cur_o), .latch_prev_o(latch_prev_o), .latch_chg_o(latch_chg_o),
    .stat_valid_o(stat_valid_o), .stat_slot_o(stat_slot_o), .stat_data_o(stat_data_o),
    .halt_done_o(halt_done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick_latch();
    if (($urandom % 3) == 0) return exp_base;
    return DW'($urandom);
  endfunction

  // Counts falling edges with no request and no halt pulse; optionally injects a stray response.
  task automatic wait_gap(output int gap, input bit inject);
    gap = 0;
    while (!req_valid_o && !halt_done_o && gap < 1000) begin
      gap++;
      if (inject && gap == 3) begin
        rsp_valid_i = 1'b1;
        rsp_data_i  = ~exp_base;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        check(!latch_chg_o && !stat_valid_o, "R9 stray rsp pulse", latch_chg_o, 0);
        check(latch_cur_o == exp_base, "R9 stray rsp baseline", latch_cur_o, exp_base);
        gap++;
        if (req_valid_o || halt_done_o) break;
      end
      @(negedge clk);
    end
  endtask

  // Serves one request; at return, the registered results of this response are checked.
  task automatic serve(input bit xl, input int xs, input logic [DW-1:0] d,
                       input bit xchg, input string tag);
    int dly;
    logic [DW-1:0] old;
    check(req_valid_o && (req_latch_o == xl), {tag, " req kind"}, req_latch_o, xl);
    check(int'(req_slot_o) == xs, {tag, " req slot"}, req_slot_o, xs);
    dly = $urandom % 4;
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check(req_valid_o && req_latch_o == xl && int'(req_slot_o) == xs,
            "R8 request held", {req_valid_o, req_latch_o}, {1'b1, xl});
    end
    old = exp_base;
    rsp_valid_i = 1'b1;
    rsp_data_i  = d;
    @(negedge clk);
    rsp_valid_i = 1'b0;
    if (xl) begin
      check(latch_chg_o == xchg, {tag, " change pulse"}, latch_chg_o, xchg);
      check(latch_cur_o == d, {tag, " latch current"}, latch_cur_o, d);
      check(latch_prev_o == old, {tag, " latch previous"}, latch_prev_o, old);
      exp_base  = d;
      have_base = 1'b1;
    end else begin
      check(stat_valid_o && int'(stat_slot_o) == xs, "R7 status slot", stat_slot_o, xs);
      check(stat_data_o == d, "R7 status data", stat_data_o, d);
      check(!latch_chg_o, "R7 no change on slot read", latch_chg_o, 0);
    end
  endtask

  initial begin
    int gap;
    bit full;
    logic [DW-1:0] d;
    void'($urandom(32'd4711));
    repeat (4) begin
      @(negedge clk);
      check(!req_valid_o && !latch_chg_o && !stat_valid_o && !halt_done_o,
            "R1 reset outputs", {req_valid_o, halt_done_o}, 0);
    end
    rst_n = 1'b1;
    for (int p = 0; p < 11; p++) begin
      wait_gap(gap, (p % 3) == 1);
      check(gap == SLEEP, (p == 0) ? "R1 first request delay" : "R2 sleep length", gap, SLEEP);
      full = (exp_pass == EVERY);
      if (full) exp_pass = 0;
      check(req_valid_o && (req_latch_o == !full), "R3 pass kind", req_latch_o, !full);
      if (!full) begin
        d = pick_latch();
        if (!have_base) serve(1'b1, 0, d, 1'b0, "R6 first capture");
        else serve(1'b1, 0, d, (d != exp_base), (d == exp_base) ? "R5 same byte" : "R4 R5 latch pass");
      end else begin
        for (int s = 0; s < NS; s++) begin
          if (p == 10 && s == 1) begin
            shutdown_i = 1'b1;
            @(negedge clk);
            shutdown_i = 1'b0;
          end
          serve(1'b0, s, DW'($urandom), 1'b0, (p == 10) ? "R11 scan continues" : "R7 slot scan");
        end
        serve(1'b1, 0, ~exp_base, 1'b0, "R7 re-read latch");
      end
      exp_pass++;
    end
    wait_gap(gap, 1'b0);
    check(halt_done_o && !req_valid_o, "R10 halt pulse", halt_done_o, 1);
    check(gap == SLEEP, "R10 halt after sleep", gap, SLEEP);
    for (int k = 0; k < 3 * SLEEP; k++) begin
      @(negedge clk);
      if (k == 5) rsp_valid_i = 1'b1;
      if (k == 6) rsp_valid_i = 1'b0;
      check(!req_valid_o && !halt_done_o && !stat_valid_o && !latch_chg_o,
            "R10 quiet after halt", {req_valid_o, halt_done_o}, 0);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule